// File: doc/BRIEF.md
# Startup Output Short Detection Sequencer

This block decides, once per logic power-up, whether the output stage may begin switching. After the power-good strobe arrives it steps through two ordered checks. The first looks for any output tied to ground. The second looks for any output tied to the supply. Throughout the check every half-bridge is held in high impedance and the shutdown line is pulled low. A failing step pauses for one window and then runs again, and this repeats until the short clears. Once both steps pass, the block releases shutdown and grants switching.

Each step lasts one window. An external timer marks the end of a window with a one-cycle strobe, and that timer's period is set from the output filter capacitance. The short flags are sampled only on that strobe. The device reset pin has no effect while the check runs. After the check it only gates the switching grant, and it never starts a second check. In single-ended output configuration the check is skipped and the block goes straight to the released state.

Top module: `out_short_seq`

## Requirements
- R1: After power-on reset (`rst_n` low) the block reports phase 00 (idle), holds `hiz_hold`=1, and drives `sd_low`=0 and `sw_grant`=0. The window strobe has no effect in this phase.
- R2: A `pwr_good` pulse in phase 00 with `se_mode`=0 enters the ground step (phase 01) on the next clock, with `hiz_hold`=1 and `sd_low`=1.
- R3: In the ground step, a `win_done` strobe with `gnd_short` all zero moves the block to the supply step (phase 10) on the next clock. The supply step is never entered from any other phase.
- R4: In the supply step, a `win_done` strobe with `sup_short` all zero moves the block to the run phase (11). In that phase `sd_low`=0, and with the reset pin high `hiz_hold`=0 and `sw_grant`=1. `sw_grant` is 1 only in phase 11.
- R5: If any flag of the current step is set at `win_done`, the block waits one further window in the same phase and then repeats that same step. A supply-step failure never returns the block to the ground step.
- R6: Flags are looked at only on the `win_done` cycle. A flag that is set and then cleared between strobes does not cause a failure, and the phase does not change without a strobe.
- R7: In phases 01 and 10, `sd_low`=1, `hiz_hold`=1 and `sw_grant`=0, whatever any other input does.
- R8: `reset_pin_n` has no effect while the check is in progress. Both the outputs and the step progression are unchanged by it.
- R9: A `pwr_good` pulse in phase 00 with `se_mode`=1 moves the block directly to phase 11.
- R10: In phase 11, `reset_pin_n` low forces `hiz_hold`=1 and `sw_grant`=0 with `sd_low`=0. Raising it restores the grant. Neither the reset pin nor `pwr_good` ever starts a new check, so phase 11 is held until power-on reset.
- R11: The ground step ignores `sup_short` and the supply step ignores `gnd_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset (logic power absent) |
| pwr_good | input | 1 | Strobe that logic supplies are up; starts the check |
| se_mode | input | 1 | 1 = single-ended configuration, check skipped |
| reset_pin_n | input | 1 | Device reset pin, active low |
| gnd_short | input | N_OUT | Per-output short-to-ground comparator flags |
| sup_short | input | N_OUT | Per-output short-to-supply comparator flags |
| win_done | input | 1 | One-cycle end-of-window strobe from the step timer |
| hiz_hold | output | 1 | 1 = all half-bridges held in high impedance |
| sd_low | output | 1 | 1 = request shutdown line low |
| phase | output | 2 | 00 idle, 01 ground step, 10 supply step, 11 run |
| sw_grant | output | 1 | 1 = switching allowed |

## Verification
The bench aims at retries. A supply-step failure must stay in the supply step, and a design that restarted from ground would show phase 01 where 10 is expected. The bench also checks that a flag cleared before the strobe does not fail the step, which catches a design that latches flags instead of sampling them at the window end. It checks that the reset pin, toggled mid-check, neither stalls nor releases anything. It checks that the flags of the other step are ignored, which catches a design that ORs both flag sets. Finally it checks that a fresh `pwr_good` or a reset pulse after the run phase never re-enters the check, and that single-ended mode goes straight to phase 11.

// File: rtl/oss_pkg.sv
package oss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GND_CHK  = 3'd1,
        ST_GND_HOLD = 3'd2,
        ST_SUP_CHK  = 3'd3,
        ST_SUP_HOLD = 3'd4,
        ST_RUN      = 3'd5
    } seq_state_e;

    localparam logic [1:0] PH_IDLE = 2'b00;
    localparam logic [1:0] PH_GND  = 2'b01;
    localparam logic [1:0] PH_SUP  = 2'b10;
    localparam logic [1:0] PH_RUN  = 2'b11;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    typedef struct packed {
        logic       hiz;
        logic       sd;
        logic       grant;
        logic [1:0] ph;
    } seq_outs_t;
endpackage

// File: rtl/oss_flag_reduce.sv
module oss_flag_reduce #(
    parameter int N_FLAGS = 4
) (
    input  logic [N_FLAGS-1:0] flags,
    output logic               any_set
);
    logic [N_FLAGS:0] chain;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_or
        assign chain[i+1] = chain[i] | flags[i];
    end

    assign any_set = chain[N_FLAGS];
endmodule

// File: rtl/oss_fsm.sv
module oss_fsm
    import oss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       se_mode,
    input  logic       win_done,
    input  logic       gnd_any,
    input  logic       sup_any,
    output seq_state_e state
);
    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (pwr_good) regs_d.st = se_mode ? ST_RUN : ST_GND_CHK;
            end
            ST_GND_CHK: begin
                if (win_done) regs_d.st = gnd_any ? ST_GND_HOLD : ST_SUP_CHK;
            end
            ST_GND_HOLD: begin
                if (win_done) regs_d.st = ST_GND_CHK;
            end
            ST_SUP_CHK: begin
                if (win_done) regs_d.st = sup_any ? ST_SUP_HOLD : ST_RUN;
            end
            ST_SUP_HOLD: begin
                if (win_done) regs_d.st = ST_SUP_CHK;
            end
            ST_RUN: begin
                regs_d.st = ST_RUN;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{st: ST_IDLE};
        else        regs_q <= regs_d;
    end

    assign state = regs_q.st;
endmodule

// File: rtl/oss_out_decode.sv
module oss_out_decode
    import oss_pkg::*;
(
    input  seq_state_e state,
    input  logic       reset_pin_n,
    output seq_outs_t  outs
);
    always_comb begin
        outs = '{hiz: 1'b1, sd: 1'b0, grant: 1'b0, ph: PH_IDLE};
        unique case (state)
            ST_IDLE: outs.ph = PH_IDLE;
            ST_GND_CHK, ST_GND_HOLD: begin
                outs.ph = PH_GND;
                outs.sd = 1'b1;
            end
            ST_SUP_CHK, ST_SUP_HOLD: begin
                outs.ph = PH_SUP;
                outs.sd = 1'b1;
            end
            ST_RUN: begin
                outs.ph    = PH_RUN;
                outs.hiz   = ~reset_pin_n;
                outs.grant = reset_pin_n;
            end
            default: outs.ph = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/out_short_seq.sv
module out_short_seq
    import oss_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             se_mode,
    input  logic             reset_pin_n,
    input  logic [N_OUT-1:0] gnd_short,
    input  logic [N_OUT-1:0] sup_short,
    input  logic             win_done,
    output logic             hiz_hold,
    output logic             sd_low,
    output logic [1:0]       phase,
    output logic             sw_grant
);
    logic       gnd_any, sup_any;
    seq_state_e state;
    seq_outs_t  outs;

    oss_flag_reduce #(.N_FLAGS(N_OUT)) u_gnd (.flags(gnd_short), .any_set(gnd_any));
    oss_flag_reduce #(.N_FLAGS(N_OUT)) u_sup (.flags(sup_short), .any_set(sup_any));

    oss_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .se_mode(se_mode),
        .win_done(win_done), .gnd_any(gnd_any), .sup_any(sup_any), .state(state)
    );

    oss_out_decode u_dec (.state(state), .reset_pin_n(reset_pin_n), .outs(outs));

    assign hiz_hold = outs.hiz;
    assign sd_low   = outs.sd;
    assign phase    = outs.ph;
    assign sw_grant = outs.grant;
endmodule

// File: rtl/oss_checker.sv
module oss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       se_mode,
    input logic       reset_pin_n,
    input logic       win_done,
    input logic [1:0] phase,
    input logic       hiz_hold,
    input logic       sd_low,
    input logic       sw_grant
);
    AST_CHECK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 || phase == 2'b10) |-> (sd_low && hiz_hold && !sw_grant)); // R7
    AST_GRANT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant |-> (phase == 2'b11 && !hiz_hold)); // R4
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11) |=> (phase == 2'b11)); // R10
    AST_SUP_AFTER_GND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && $past(phase) != 2'b10) |-> ($past(phase) == 2'b01)); // R3
    AST_NO_STROBE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'b01 || phase == 2'b10) && !win_done) |=> $stable(phase)); // R6
    AST_SUP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10) |=> (phase != 2'b01)); // R5
    AST_PIN_LOW_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && !reset_pin_n) |-> (hiz_hold && !sw_grant && !sd_low)); // R10
    AST_SE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && pwr_good && se_mode) |=> (phase == 2'b11)); // R9
endmodule

bind out_short_seq oss_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .se_mode(se_mode),
    .reset_pin_n(reset_pin_n), .win_done(win_done), .phase(phase),
    .hiz_hold(hiz_hold), .sd_low(sd_low), .sw_grant(sw_grant)
);

// File: tb/sim_out_short_seq.sv
`timescale 1ns/1ps
module sim_out_short_seq;
    localparam int N = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, se_mode = 1'b0, reset_pin_n = 1'b1, win_done = 1'b0;
    logic [N-1:0] gnd_short = '0, sup_short = '0;
    logic hiz_hold, sd_low, sw_grant;
    logic [1:0] phase;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    out_short_seq #(.N_OUT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .se_mode(se_mode),
        .reset_pin_n(reset_pin_n), .gnd_short(gnd_short), .sup_short(sup_short),
        .win_done(win_done), .hiz_hold(hiz_hold), .sd_low(sd_low),
        .phase(phase), .sw_grant(sw_grant)
    );

    // vector: [16]pwr [15]se [14]pin [13:10]gnd [9:6]sup [5]win | [4:3]phase [2]hiz [1]sd [0]grant
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        17'b0_0_1_0000_0000_1_00_1_0_0, // R1 strobe in idle ignored
        17'b1_0_1_0000_0000_0_01_1_1_0, // R2 enter ground step
        17'b0_0_1_0100_0000_1_01_1_1_0, // R5 ground fail -> hold
        17'b0_0_0_0000_0000_0_01_1_1_0, // R8 pin low ignored
        17'b0_0_1_0000_0000_1_01_1_1_0, // R5 retry ground step
        17'b0_0_1_0001_0000_0_01_1_1_0, // R6 transient flag
        17'b0_0_0_0000_1111_1_10_1_1_0, // R3 R11 R8 pass with pin low
        17'b0_0_1_0000_1000_1_10_1_1_0, // R5 supply fail
        17'b0_0_1_1111_0000_1_10_1_1_0, // R5 back to supply check
        17'b0_0_1_1111_0000_1_11_0_0_1, // R4 R11 pass
        17'b0_0_0_0000_0000_0_11_1_0_0, // R10 pin low in run
        17'b1_0_1_0000_0000_0_11_0_0_1  // R10 no new check
    };

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {phase, hiz_hold, sd_low, sw_grant};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act phase/hiz/sd/grant=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [16:0] v);
        @(negedge clk);
        pwr_good = v[16]; se_mode = v[15]; reset_pin_n = v[14];
        gnd_short = v[13:10]; sup_short = v[9:6]; win_done = v[5];
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwr_good = 0; se_mode = 0; reset_pin_n = 1;
        gnd_short = '0; sup_short = '0; win_done = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    initial begin
        do_reset();
        check("R1", 5'b00_1_0_0);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("vec%0d", i), VEC[i][4:0]);
        end
        apply(17'b0_0_1_0000_0000_0_00000);
        check("R10", 5'b11_0_0_1);
        // single-ended skip
        do_reset();
        check("R1", 5'b00_1_0_0);
        apply(17'b1_1_1_0000_0000_0_00000);
        check("R9", 5'b11_0_0_1);
        // repeated supply failure never returns to ground step
        do_reset();
        apply(17'b1_0_1_0000_0000_0_00000);
        apply(17'b0_0_1_0000_0000_1_00000);
        check("R3", 5'b10_1_1_0);
        for (int k = 0; k < 4; k++) begin
            apply(17'b0_0_1_0000_0010_1_00000);
            check("R5", 5'b10_1_1_0);
        end
        apply(17'b0_0_0_0000_0000_0_00000);
        check("R7", 5'b10_1_1_0);
        apply(17'b0_0_1_0000_0000_1_00000);
        check("R4", 5'b11_0_0_1);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=timeout expected=finish");
        end
        #1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule